// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block is a bus slave that exposes two internal register regions through two small windows, each made of an address register, a data register and a control register. One window reaches a region of 32-bit registers. The other reaches a region of 8-bit registers. Software selects a target register by writing its address into the window's address register. It then moves data through the window's data register.

The bridge enforces a strict access ritual. The target address must be written twice in a row, with the same value, before a data access is accepted. A read takes two data-register reads. The first read launches the internal fetch and returns the old read buffer, so only the second read carries the requested value. A write takes one data-register write.

The host side is a zero-wait-state APB-style bus. An access completes in the cycle where `psel` and `penable` are both high. The two regions are modelled as small register arrays that are cleared by reset.

Top module: `regwin_bridge`

## Requirements
- R1: Address decode uses `paddr`.
  - The 32-bit window is at 0x00 and the 8-bit window is at 0x10.
  - Inside a window, the address register is at offset 0x0, the data register at 0x4 and the control register at 0x8.
  - Offset 0xC, and any address with bits above bit 4 set, reads zero, ignores writes and never raises `pslverr`.
- R2: The address register keeps only the low 16 bits of the written value. A read of it returns those bits zero-extended to 32 bits.
- R3: A window becomes armed only when an address write carries the same low 16 bits as the address already held, and the previous access to that same window was also an address write. Any address write that does not meet this condition disarms the window. Data and control accesses leave the armed state as it is.
- R4: Each read of an armed data register returns the window's read buffer and reloads the buffer from the region at the latched address. As a result, the second of two reads returns the fresh value.
- R5: One write to an armed data register stores the value at the latched address. The 32-bit region stores all 32 bits. The 8-bit region stores bits 7:0.
- R6: A data access to a window that is not armed has no effect:
  - writes are dropped;
  - reads return zero and leave the read buffer as it was;
  - `pslverr` is raised for the access only when bit 15 of that window's control register is set.
- R7: Bit 15 of the control register is the only stored control bit. It reads back at bit 15 and all other bits read zero. `pslverr` is only ever high during an access to a data register.
- R8: Reads from the 8-bit region are zero-extended to 32 bits on `prdata`.
- R9: The two windows are independent. Accesses to one window never change the other window's address, armed state, control bit or read buffer.
- R10: After reset, every address register, read buffer, control bit and region location is zero, and both windows are disarmed.
- Region locations are selected by the low bits of the latched address: 4 bits for the 16-entry 32-bit region and 6 bits for the 64-entry 8-bit region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase; the access completes when it is high together with psel |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pslverr | output | 1 | Error flag for an unarmed data access when enabled |

## Verification
The bench covers the following arming cases:
- a lone address write followed by a data access;
- two different address values written back to back;
- a pair of address writes broken by a control access;
- pairs of address writes interleaved across the two windows.

A design that counted address writes without comparing their values, or that shared arming state between the windows, would accept accesses that must be dropped.

The bench also checks that the first read after arming returns the stale buffer, and that a design which fetched and returned in the same read fails. It checks that unarmed writes leave the region untouched and that the error flag follows the control bit. Finally, it checks that 16-bit truncation of the address, aliasing into the small regions, and byte truncation in the 8-bit region all appear at the ports.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } regwin_sel_e;

  localparam int unsigned ADDR_KEEP_W = 16;
  localparam int unsigned ERRFAIL_BIT = 15;
  localparam int unsigned WIN_BIT     = 4;
  localparam int unsigned SPACE_BITS  = 5;
endpackage

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        wr,
  input  regwin_sel_e sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic        err
);
  logic [ADDR_KEEP_W-1:0] addr_q;
  logic armed_q, last_addr_q, errfail_q;
  logic [DW-1:0] buf_q, mem_rd;
  logic is_addr_wr, is_data, is_ctrl, data_ok, mem_we, fetch;

  assign is_addr_wr = acc && wr && (sel == REG_ADDR);
  assign is_data    = acc && (sel == REG_DATA);
  assign is_ctrl    = acc && (sel == REG_CTRL);
  assign data_ok    = is_data && armed_q;
  assign mem_we     = data_ok && wr;
  assign fetch      = data_ok && !wr;

  regwin_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .idx   (addr_q[IW-1:0]),
    .wdata (wdata[DW-1:0]),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      armed_q     <= 1'b0;
      last_addr_q <= 1'b0;
      errfail_q   <= 1'b0;
      buf_q       <= '0;
    end else begin
      if (is_addr_wr) begin
        armed_q     <= last_addr_q && (wdata[ADDR_KEEP_W-1:0] == addr_q);
        addr_q      <= wdata[ADDR_KEEP_W-1:0];
        last_addr_q <= 1'b1;
      end else if (acc) begin
        last_addr_q <= 1'b0;
      end
      if (is_ctrl && wr) errfail_q <= wdata[ERRFAIL_BIT];
      if (fetch) buf_q <= mem_rd;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      REG_ADDR: rdata[ADDR_KEEP_W-1:0] = addr_q;
      REG_DATA: if (armed_q) rdata[DW-1:0] = buf_q;
      REG_CTRL: rdata[ERRFAIL_BIT] = errfail_q;
      default:  rdata = '0;
    endcase
  end

  assign err = is_data && !armed_q && errfail_q;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int unsigned PADDR_W    = 8,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned GLUE_W     = 32,
  parameter int unsigned GLUE_DEPTH = 16,
  parameter int unsigned CORE_W     = 8,
  parameter int unsigned CORE_DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]   pwdata,
  output logic [BUS_W-1:0]   prdata,
  output logic               pslverr
);
  localparam int unsigned NWIN = 2;

  logic        acc, in_space;
  regwin_sel_e sel;
  logic [NWIN-1:0]  win_acc, win_err;
  logic [BUS_W-1:0] win_rd [NWIN];

  assign acc      = psel && penable;
  assign in_space = (paddr >> SPACE_BITS) == '0;

  always_comb begin
    unique case (paddr[3:2])
      2'd0:    sel = REG_ADDR;
      2'd1:    sel = REG_DATA;
      2'd2:    sel = REG_CTRL;
      default: sel = REG_NONE;
    endcase
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam int unsigned DW    = (w == 0) ? GLUE_W : CORE_W;
    localparam int unsigned DEPTH = (w == 0) ? GLUE_DEPTH : CORE_DEPTH;

    assign win_acc[w] = acc && in_space && (sel != REG_NONE) && (paddr[WIN_BIT] == 1'(w));

    regwin_port #(.BUS_W(BUS_W), .DW(DW), .DEPTH(DEPTH)) port_i (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (win_acc[w]),
      .wr    (pwrite),
      .sel   (sel),
      .wdata (pwdata),
      .rdata (win_rd[w]),
      .err   (win_err[w])
    );
  end

  assign prdata  = (in_space && sel != REG_NONE) ? win_rd[paddr[WIN_BIT]] : '0;
  assign pslverr = |win_err;
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int unsigned PADDR_W = 8,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned CORE_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [PADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]   prdata,
  input logic               pslverr
);
  logic rd_acc, unmapped;
  assign rd_acc   = psel && penable && !pwrite;
  assign unmapped = ((paddr >> 5) != '0) || (paddr[3:2] == 2'd3);

  assert_err_on_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable && paddr[3:2] == 2'd1));

  assert_err_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pslverr && !pwrite) |-> (prdata == '0));

  assert_core_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !unmapped && paddr[4] && paddr[3:2] == 2'd1) |-> ((prdata >> CORE_W) == '0));

  assert_ctrl_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !unmapped && paddr[3:2] == 2'd2) |-> ((prdata & ~(BUS_W'(1) << 15)) == '0));

  assert_addr_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !unmapped && paddr[3:2] == 2'd0) |-> ((prdata >> 16) == '0));

  assert_unmapped_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && unmapped) |-> (!pslverr && prdata == '0));
endmodule

bind regwin_bridge regwin_bridge_chk #(.PADDR_W(PADDR_W), .BUS_W(BUS_W), .CORE_W(CORE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pslverr(pslverr)
);

// File: tb/regwin_bridge_tb_top.sv
module regwin_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pslverr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_glue [16];
  logic [7:0]  m_core [64];
  logic [15:0] m_addr [2];
  logic        m_armed [2];
  logic        m_last [2];
  logic        m_ef [2];
  logic [31:0] m_buf [2];

  regwin_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] a, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, a, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] a, input bit wr, input logic [31:0] wd,
                       output logic [31:0] rd, output bit er, output string tag);
    int w;
    rd = '0; er = 1'b0; tag = "R1";
    if ((a >> 5) != 0 || a[3:2] == 2'd3) return;
    w = int'(a[4]);
    if (a[3:2] == 2'd0) begin
      tag = "R2";
      if (wr) begin
        m_armed[w] = m_last[w] && (wd[15:0] == m_addr[w]);
        m_addr[w] = wd[15:0];
        m_last[w] = 1'b1;
      end else begin
        rd = {16'h0, m_addr[w]};
        m_last[w] = 1'b0;
      end
    end else if (a[3:2] == 2'd1) begin
      m_last[w] = 1'b0;
      if (!m_armed[w]) begin
        tag = "R6"; er = m_ef[w];
      end else if (wr) begin
        tag = "R5";
        if (w == 0) m_glue[m_addr[w][3:0]] = wd;
        else m_core[m_addr[w][5:0]] = wd[7:0];
      end else begin
        tag = (w == 0) ? "R4" : "R8";
        rd = m_buf[w];
        m_buf[w] = (w == 0) ? m_glue[m_addr[w][3:0]] : {24'h0, m_core[m_addr[w][5:0]]};
      end
    end else begin
      tag = "R7";
      m_last[w] = 1'b0;
      if (wr) m_ef[w] = wd[15];
      else rd = {16'h0, m_ef[w], 15'h0};
    end
  endtask

  task automatic bus(input logic [7:0] a, input bit wr, input logic [31:0] wd,
                     output logic [31:0] rd, output bit er);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; er = pslverr;
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic op(input logic [7:0] a, input bit wr, input logic [31:0] wd, input string tag_o);
    logic [31:0] exp_d, act_d;
    bit exp_e, act_e;
    string tag;
    model(a, wr, wd, exp_d, exp_e, tag);
    if (tag_o != "") tag = tag_o;
    bus(a, wr, wd, act_d, act_e);
    check(tag, a, {31'h0, act_e}, {31'h0, exp_e}, "pslverr");
    if (!wr) check(tag, a, act_d, exp_d, "prdata");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 16; i++) m_glue[i] = '0;
    for (int i = 0; i < 64; i++) m_core[i] = '0;
    for (int w = 0; w < 2; w++) begin
      m_addr[w] = '0; m_armed[w] = 0; m_last[w] = 0; m_ef[w] = 0; m_buf[w] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    op(8'h00, 0, 0, "R10");
    op(8'h08, 0, 0, "R10");
    op(8'h14, 0, 0, "R10");
    op(8'h10, 0, 0, "R10");

    // R3/R6: lone address write, then errored access; R4/R5: armed write and double read
    op(8'h08, 1, 32'h0000_8000, "R7");
    op(8'h00, 1, 32'h3, "R3");
    op(8'h04, 0, 0, "R3");
    op(8'h00, 1, 32'h3, "R3");
    op(8'h00, 1, 32'h3, "R3");
    op(8'h04, 1, 32'hDEAD_BEEF, "R5");
    op(8'h04, 0, 0, "R4");
    op(8'h04, 0, 0, "R4");

    // R3: mismatched pair; R6: unarmed write is dropped
    op(8'h00, 1, 32'h5, "R3");
    op(8'h00, 1, 32'h6, "R3");
    op(8'h04, 1, 32'h1234_5678, "R6");
    op(8'h00, 1, 32'h6, "R3");
    op(8'h04, 0, 0, "R6");
    op(8'h04, 0, 0, "R6");

    // R3: pair broken by a control access
    op(8'h00, 1, 32'h3, "R3");
    op(8'h08, 0, 0, "R7");
    op(8'h00, 1, 32'h3, "R3");
    op(8'h04, 0, 0, "R3");

    // R8/R5/R2: 8-bit window, byte truncation, 16-bit address truncation
    op(8'h10, 1, 32'h1234_0021, "R2");
    op(8'h10, 1, 32'hFFFF_0021, "R2");
    op(8'h10, 0, 0, "R2");
    op(8'h14, 1, 32'hABCD_EF5A, "R5");
    op(8'h14, 0, 0, "R8");
    op(8'h14, 0, 0, "R8");

    // R9: interleaved pairs across windows
    op(8'h00, 1, 32'h8, "R9");
    op(8'h10, 1, 32'h8, "R9");
    op(8'h00, 1, 32'h8, "R9");
    op(8'h04, 1, 32'hCAFE_0001, "R9");
    op(8'h14, 0, 0, "R9");
    op(8'h04, 0, 0, "R9");
    op(8'h04, 0, 0, "R9");

    // R1: unmapped addresses
    op(8'h0C, 1, 32'hFFFF_FFFF, "R1");
    op(8'h20, 1, 32'hFFFF_FFFF, "R1");
    op(8'h44, 1, 32'hFFFF_FFFF, "R1");
    op(8'h0C, 0, 0, "R1");
    op(8'h20, 0, 0, "R1");
    op(8'h44, 0, 0, "R1");
    op(8'h00, 0, 0, "R1");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [7:0] base;
      logic [31:0] wd;
      r = $urandom % 16;
      base = ($urandom % 2) ? 8'h10 : 8'h00;
      wd = $urandom;
      if (r < 5) begin
        if ($urandom % 2) wd[15:0] = m_addr[base[4]];
        else if ($urandom % 2) wd[31:6] = '0;
        op(base, 1, wd, "");
      end else if (r < 9) op(base | 8'h04, 0, 0, "");
      else if (r < 12) op(base | 8'h04, 1, wd, "");
      else if (r == 12) op(base | 8'h08, 1, wd, "");
      else if (r == 13) op(base | 8'h08, 0, 0, "");
      else if (r == 14) op(base, 0, 0, "");
      else begin
        logic [7:0] ua;
        ua = (($urandom % 2) ? 8'h0C : 8'h20) | base | 8'(($urandom % 4) << 5);
        op(ua, $urandom % 2, wd, "R1");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule